// File: doc/BRIEF.md
# Periodic Multi-Lane Pulse Train Generator

This block produces a fixed stimulus waveform for exercising a time-to-digital converter front end. One clock cycle is one tick of timing resolution. With the default 6 ns tick, a frame is 66 ticks, or 396 ns. Each frame holds three pulses:

- a single-tick pulse at the start of the frame;
- a single-tick pulse 24 ns later;
- a two-tick pulse 90 ns after the frame start.

The same waveform is driven onto every output lane at the same time. The outputs come straight from flops, so all lanes switch on one clock edge.

By default the frame counter runs free. When the alignment select is high, each rising edge seen on the sync input restarts the frame. This lets the pattern be phase-locked to an external bunch clock. A frame-start strobe marks tick 0 of every frame and can serve as a scope or bench trigger.

The enable input gates the generator. While enable is low, the block is parked. When enable is raised, the pattern starts from tick 0. A synchronous reset also restarts the pattern from tick 0.

Top module: `pulse_train_gen`

## Requirements
- R1: While `rst` is high at a clock edge, `lanes` and `frame_start` are 0 after that edge. This holds whatever the values of the other inputs.
- R2: Within a frame, with ticks numbered 0 to 65 from the frame start, the lanes are 1 at ticks 0, 4, 15 and 16. At every other tick the lanes are 0.
- R3: When no sync edge restarts it, the frame repeats with a period of exactly 66 clock cycles.
- R4: In every cycle, all 12 bits of `lanes` carry the same value.
- R5: While `en` is low at a clock edge, `lanes` and `frame_start` are 0 after that edge. At the first edge where `en` is high (with `rst` low), tick 0 appears.
- R6: `frame_start` is 1 exactly in the cycles that show tick 0, and is 0 in all other cycles.
- R7: Consider an edge where `align_en` is high and `sync_in` is 1, while at the previous edge `sync_in` was 0 (or `rst` was high). After that edge, the outputs show tick 0 of a new frame.
- R8: While `align_en` is low, `sync_in` has no effect on the outputs.
- R9: Holding `sync_in` high does not restart the frame again. Only a 0-to-1 change restarts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock, one period per time step |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Runs the generator when high |
| align_en | input | 1 | Selects restart of the frame on sync edges |
| sync_in | input | 1 | External bunch-clock sync, sampled at the clock |
| lanes | output | 12 | Identical pulse pattern on every lane |
| frame_start | output | 1 | High for the single tick 0 of each frame |

## Verification
A corrupted frame counter shows up at the ports within one frame. Either the pulses land on the wrong ticks, or the interval between `frame_start` strobes differs from 66 cycles. The bench's per-cycle model catches such an error on the first mismatched tick. A stale sync history shows up as a missing restart, or as a spurious one, in the cycle right after the sync edge. A lane fan-out fault shows up as differing lane bits in any cycle with a pulse.

// File: rtl/pulse_train_gen.sv
module pulse_train_gen #(
  parameter int LANES = 12,
  parameter int FRAME = 66,
  parameter int P1_AT = 0,
  parameter int P1_LEN = 1,
  parameter int P2_AT = 4,
  parameter int P2_LEN = 1,
  parameter int P3_AT = 15,
  parameter int P3_LEN = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             align_en,
  input  logic             sync_in,
  output logic [LANES-1:0] lanes,
  output logic             frame_start
);
  localparam int CW = (FRAME > 1) ? $clog2(FRAME) : 1;
  localparam logic [CW-1:0] LAST = CW'(FRAME - 1);

  logic [CW-1:0] cnt, nxt;
  logic          run, sync_q;
  logic          restart;

  function automatic logic in_pulse(input logic [CW-1:0] t);
    int v;
    v = int'(t);
    return (v >= P1_AT && v < P1_AT + P1_LEN) ||
           (v >= P2_AT && v < P2_AT + P2_LEN) ||
           (v >= P3_AT && v < P3_AT + P3_LEN);
  endfunction

  assign restart = !run || (align_en && sync_in && !sync_q);

  always_comb begin
    if (restart || cnt == LAST) nxt = '0;
    else                        nxt = cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    sync_q <= rst ? 1'b0 : sync_in;
    if (rst || !en) begin
      run         <= 1'b0;
      cnt         <= '0;
      lanes       <= '0;
      frame_start <= 1'b0;
    end else begin
      run         <= 1'b1;
      cnt         <= nxt;
      lanes       <= {LANES{in_pulse(nxt)}};
      frame_start <= (nxt == '0);
    end
  end
endmodule

// File: rtl/pulse_train_gen_chk.sv
module pulse_train_gen_chk #(
  parameter int LANES = 12
) (
  input logic             clk,
  input logic             rst,
  input logic             en,
  input logic             align_en,
  input logic             sync_in,
  input logic [LANES-1:0] lanes,
  input logic             frame_start
);
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (lanes == '0 && !frame_start));

  p_lanes_same_r4: assert property (@(posedge clk) disable iff (rst)
    (lanes == '0 || lanes == {LANES{1'b1}}));

  p_idle_low_r5: assert property (@(posedge clk) disable iff (rst)
    !en |=> (lanes == '0 && !frame_start));

  p_start_r5: assert property (@(posedge clk) disable iff (rst)
    (!en ##1 en) |=> frame_start);

  p_strobe_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    frame_start |-> lanes == {LANES{1'b1}});

  p_gap_after_start_r2: assert property (@(posedge clk) disable iff (rst)
    (frame_start && en && !(align_en && sync_in)) |=> (lanes == '0 && !frame_start));

  p_sync_restart_r7: assert property (@(posedge clk) disable iff (rst)
    (en && align_en && sync_in && !$past(sync_in) && !$past(rst)) |=> frame_start);
endmodule

bind pulse_train_gen pulse_train_gen_chk #(.LANES(LANES)) u_chk (
  .clk(clk), .rst(rst), .en(en), .align_en(align_en), .sync_in(sync_in),
  .lanes(lanes), .frame_start(frame_start)
);

// File: tb/pulse_train_gen_test.sv
module pulse_train_gen_test;
  localparam int CLK_PERIOD = 6;
  localparam int N = 12;

  logic clk = 0, rst = 1, en = 0, align_en = 0, sync_in = 0;
  logic [N-1:0] lanes;
  logic frame_start;

  pulse_train_gen uut (
    .clk(clk), .rst(rst), .en(en), .align_en(align_en), .sync_in(sync_in),
    .lanes(lanes), .frame_start(frame_start)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0;
  int m_tick = 0, m_run = 0, m_psync = 0;
  int exp_pulse = 0, exp_fs = 0;
  int cycle = 0, last_fs = -1;
  string tag = "R1";
  bit done = 0;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s cycle %0d: actual %0d expected %0d", req, cycle, act, exp);
    end
  endtask

  // behavioural model of the next clock edge, from current inputs
  task automatic model_edge();
    int rise;
    rise = (sync_in && !m_psync) ? 1 : 0;
    if (rst || !en) begin
      m_run = 0; m_tick = 0; exp_pulse = 0; exp_fs = 0;
    end else begin
      if (!m_run || (align_en && rise)) m_tick = 0;
      else m_tick = (m_tick + 1) % 66;
      m_run = 1;
      exp_pulse = (m_tick == 0 || m_tick == 4 || m_tick == 15 || m_tick == 16) ? 1 : 0;
      exp_fs = (m_tick == 0) ? 1 : 0;
    end
    m_psync = rst ? 0 : (sync_in ? 1 : 0);
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      model_edge();
      @(negedge clk);
      cycle++;
      check(tag, (lanes == '0) ? 0 : (lanes == '1 ? 1 : 2), exp_pulse);
      if (lanes != '0 && lanes != '1) check("R4", 1, 0);
      check({tag, "/R6 strobe"}, int'(frame_start), exp_fs);
      if (frame_start) begin
        if (tag == "R3" && last_fs >= 0) check("R3 period", cycle - last_fs, 66);
        last_fs = cycle;
      end
    end
  endtask

  initial begin
    @(negedge clk);
    tag = "R1"; rst = 1; en = 1; sync_in = 1; align_en = 1;
    step(3);
    rst = 0; sync_in = 0; align_en = 0;
    tag = "R2";
    step(66);
    tag = "R3";
    step(140);
    tag = "R5"; en = 0;
    step(5);
    en = 1;
    step(20);
    tag = "R8"; align_en = 0;
    for (int k = 0; k < 4; k++) begin
      sync_in = 1; step(2); sync_in = 0; step(7);
    end
    tag = "R7"; align_en = 1;
    sync_in = 1; step(1); sync_in = 0; step(30);
    sync_in = 1; step(1); sync_in = 0; step(10);
    tag = "R9"; sync_in = 1;
    step(150);
    sync_in = 0;
    tag = "R1"; rst = 1;
    step(2);
    rst = 0; tag = "R2";
    step(30);
    done = 1;
  end

  initial begin
    for (int w = 0; w < 100000 && !done; w++) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule